// File: doc/BRIEF.md
# Cross-Trigger Handshake Controller

This block is the trigger-exchange logic of an on-chip debug capture unit. It lets several capture units, or a capture unit and a processor, start each other's captures. A trigger event is either a met local trigger condition or an asserted trigger input. When an event arrives, the block waits a fixed latency and then raises its trigger output. It holds that output as a level until the receiver acknowledges it, following a four-phase handshake. Every incoming trigger is acknowledged one cycle after it appears, and that acknowledge falls only once the incoming trigger falls.

All inputs are synchronous to the single capture clock, so the block has no synchronizer. After reset or a rearm pulse, the unit is armed. It accepts only the first event and then ignores further events until the next rearm. A rearm flushes any event still travelling through the delay line. It also drops a held trigger output, which is the only way out when the receiver never acknowledges. A triggered status bit marks that the trigger output has fired since the last arm.

Two units can be chained. The first unit's trigger output feeds the second unit's trigger input, and the second unit's input acknowledge returns as the first unit's output acknowledge.

Top module: `xtrig_handshake_top`

## Requirements
- R1: A synchronous active-high `rst` clears `trigOut`, `trigInAck` and `triggered` at the next clock edge. It also discards any event in flight, so no trigger output follows. After reset the unit is armed.
- R2: `trigInAck` is high in a cycle exactly when `trigIn` was high in the previous cycle. It rises one cycle after `trigIn` rises and falls one cycle after `trigIn` falls, whether or not the unit is armed.
- R3: Suppose an event (`trigIn` or `localHit` high) is sampled at clock edge e while the unit is armed and `rearmPulse` is low. Then `trigOut` goes high at edge e+LATENCY-1, that is, in the 9th cycle counted from the cycle the event was presented (LATENCY = 9).
- R4: Once high, `trigOut` stays high while `trigOutAck` is sampled low. It goes low at the first edge at which `trigOutAck` is sampled high while `trigOut` is high.
- R5: Only the first event after arming is accepted. Further events, including a continuously held one, produce no further rise of `trigOut` until a rearm.
- R6: A `rearmPulse` sampled high clears `trigOut`, `triggered` and every event in flight at that edge, and re-arms the unit. An event sampled in the same cycle as the rearm is ignored.
- R7: `triggered` goes high at the same edge at which `trigOut` first rises, and stays high until the next rearm or reset, even after `trigOut` has dropped.
- R8: In a chain of two units, an event at unit A raises A's output after 9 cycles. B acknowledges one cycle later, and A's output drops one cycle after that. B's own output rises 9 cycles after it saw A's trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock |
| rst | input | 1 | Synchronous active-high reset |
| rearmPulse | input | 1 | Rearm request, one cycle high |
| localHit | input | 1 | Local trigger condition met |
| trigIn | input | 1 | Trigger from another unit |
| trigInAck | output | 1 | Acknowledge of `trigIn` |
| trigOut | output | 1 | Trigger level to another unit |
| trigOutAck | input | 1 | Acknowledge of `trigOut` from the receiver |
| triggered | output | 1 | Trigger has fired since last arm |

## Verification
The hardest situation to reach is a rearm that lands while an event is still inside the delay line. The trigger output is still low at that point, so only the absence of a later rise shows that the flush worked. The bench launches an event, issues the rearm a few cycles later, and then watches the output for a full latency window past the point where the stale event would have surfaced. The same approach is applied to a reset during flight. Chaining is exercised with two instances wired back to back, so that the acknowledge timing of the receiving unit sets when the sender releases its output.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;

  // Strobes from the control module into the delay datapath
  typedef struct packed {
    logic launch;  // accept an event into the delay line
    logic flush;   // rearm: empty the delay line, clear status and output
    logic drop;    // receiver acknowledged the held trigger output
  } xtrigStrobes_t;

endpackage

// File: rtl/xtrig_ctrl.sv
module xtrig_ctrl
  import xtrig_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          rearmPulse,
  input  logic          localHit,
  input  logic          trigIn,
  input  logic          trigOutAck,
  input  logic          outLevel,
  output xtrigStrobes_t strobes,
  output logic          trigInAck
);

  logic armed;
  logic eventSeen;

  assign eventSeen = trigIn | localHit;

  always_comb begin
    strobes.flush  = rearmPulse;
    strobes.launch = armed & ~rearmPulse & eventSeen;
    strobes.drop   = outLevel & trigOutAck;
  end

  // One-shot arming: cleared by the accepted event, restored by rearm
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b1;
    end else if (rearmPulse) begin
      armed <= 1'b1;
    end else if (strobes.launch) begin
      armed <= 1'b0;
    end
  end

  // Input acknowledge follows the trigger input with one cycle of delay
  always_ff @(posedge clk) begin
    if (rst) begin
      trigInAck <= 1'b0;
    end else begin
      trigInAck <= trigIn;
    end
  end

endmodule

// File: rtl/xtrig_delay_path.sv
module xtrig_delay_path
  import xtrig_pkg::*;
#(
  parameter int LATENCY = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  xtrigStrobes_t strobes,
  output logic          trigOut,
  output logic          triggered
);

  localparam int DEPTH = LATENCY - 1;

  logic [DEPTH-1:0] pipe;
  logic             tailHit;

  assign tailHit = pipe[DEPTH-1];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst || strobes.flush) begin
          pipe[0] <= 1'b0;
        end else begin
          pipe[0] <= strobes.launch;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst || strobes.flush) begin
          pipe[k] <= 1'b0;
        end else begin
          pipe[k] <= pipe[k-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobes.flush) begin
      trigOut <= 1'b0;
    end else if (strobes.drop) begin
      trigOut <= 1'b0;
    end else if (tailHit) begin
      trigOut <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobes.flush) begin
      triggered <= 1'b0;
    end else if (tailHit) begin
      triggered <= 1'b1;
    end
  end

endmodule

// File: rtl/xtrig_handshake_top.sv
module xtrig_handshake_top
  import xtrig_pkg::*;
#(
  parameter int LATENCY = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic rearmPulse,
  input  logic localHit,
  input  logic trigIn,
  output logic trigInAck,
  output logic trigOut,
  input  logic trigOutAck,
  output logic triggered
);

  xtrigStrobes_t strobes;

  xtrig_ctrl ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .rearmPulse (rearmPulse),
    .localHit   (localHit),
    .trigIn     (trigIn),
    .trigOutAck (trigOutAck),
    .outLevel   (trigOut),
    .strobes    (strobes),
    .trigInAck  (trigInAck)
  );

  xtrig_delay_path #(.LATENCY(LATENCY)) path_i (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .trigOut   (trigOut),
    .triggered (triggered)
  );

endmodule

// File: rtl/xtrig_handshake_chk.sv
module xtrig_handshake_chk (
  input logic clk,
  input logic rst,
  input logic rearmPulse,
  input logic trigIn,
  input logic trigInAck,
  input logic trigOut,
  input logic trigOutAck,
  input logic triggered
);

  AST_INACK_RISE: assert property (@(posedge clk) disable iff (rst) trigIn |=> trigInAck); // R2
  AST_INACK_FALL: assert property (@(posedge clk) disable iff (rst) !trigIn |=> !trigInAck); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst) (trigOut && !trigOutAck && !rearmPulse) |=> trigOut); // R4
  AST_OUT_DROP: assert property (@(posedge clk) disable iff (rst) (trigOut && trigOutAck) |=> !trigOut); // R4
  AST_REARM_CLEAR: assert property (@(posedge clk) disable iff (rst) rearmPulse |=> (!trigOut && !triggered)); // R6
  AST_STATUS_WITH_OUT: assert property (@(posedge clk) disable iff (rst) $rose(trigOut) |-> triggered); // R7
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst) (triggered && !rearmPulse) |=> triggered); // R7
  AST_SINGLE_SHOT: assert property (@(posedge clk) disable iff (rst) (triggered && !trigOut) |=> !$rose(trigOut)); // R5

endmodule

bind xtrig_handshake_top xtrig_handshake_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .rearmPulse (rearmPulse),
  .trigIn     (trigIn),
  .trigInAck  (trigInAck),
  .trigOut    (trigOut),
  .trigOutAck (trigOutAck),
  .triggered  (triggered)
);

// File: tb/xtrig_handshake_top_tb_top.sv
`timescale 1ns/1ps
module xtrig_handshake_top_tb_top;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, rearmPulse, localHit, trigIn, trigOutAck;
  logic trigInAck, trigOut, triggered;

  logic aRearm, aLocal, aIn, aAck, aInAck, aOut, aTrig;
  logic bRearm, bLocal, bOutAck, bInAck, bOut, bTrig;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  xtrig_handshake_top #(.LATENCY(9)) dut_i (
    .clk(clk), .rst(rst), .rearmPulse(rearmPulse), .localHit(localHit),
    .trigIn(trigIn), .trigInAck(trigInAck), .trigOut(trigOut),
    .trigOutAck(trigOutAck), .triggered(triggered)
  );

  // Chained pair: A drives B, B acknowledges A
  xtrig_handshake_top #(.LATENCY(9)) chainA_i (
    .clk(clk), .rst(rst), .rearmPulse(aRearm), .localHit(aLocal),
    .trigIn(aIn), .trigInAck(aInAck), .trigOut(aOut),
    .trigOutAck(aAck), .triggered(aTrig)
  );

  xtrig_handshake_top #(.LATENCY(9)) chainB_i (
    .clk(clk), .rst(rst), .rearmPulse(bRearm), .localHit(bLocal),
    .trigIn(aOut), .trigInAck(bInAck), .trigOut(bOut),
    .trigOutAck(bOutAck), .triggered(bTrig)
  );

  assign aAck = bInAck;

  // Row: [6]trigIn [5]localHit [4]rearmPulse [3]trigOutAck
  //      [2]exp trigOut [1]exp trigInAck [0]exp triggered (after the edge)
  localparam logic [6:0] VEC [0:32] = '{
    7'b0100_000, 7'b0000_000, 7'b0000_000, 7'b0000_000, 7'b0000_000,
    7'b0000_000, 7'b0000_000, 7'b0000_000, 7'b0000_101, 7'b1000_111,
    7'b0001_001, 7'b0000_001, 7'b0010_000, 7'b1000_010, 7'b0000_000,
    7'b0000_000, 7'b0000_000, 7'b0000_000, 7'b0000_000, 7'b0000_000,
    7'b0000_000, 7'b0000_101, 7'b0000_101, 7'b0110_000, 7'b0000_000,
    7'b0000_000, 7'b0000_000, 7'b0000_000, 7'b0000_000, 7'b0000_000,
    7'b0000_000, 7'b0000_000, 7'b0000_000
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    trigIn = 1'b0; localHit = 1'b0; rearmPulse = 1'b0; trigOutAck = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    idle();
    aRearm = 0; aLocal = 0; aIn = 0; bRearm = 0; bLocal = 0; bOutAck = 0;
    rst = 1'b1;
    step(); step();
    chk("R1", "reset trigOut", trigOut, 1'b0);
    chk("R1", "reset trigInAck", trigInAck, 1'b0);
    chk("R1", "reset triggered", triggered, 1'b0);
    rst = 1'b0;

    // Vector table: latency, hold, ack drop, rearm priority, single shot
    for (int i = 0; i < 33; i++) begin
      trigIn     = VEC[i][6];
      localHit   = VEC[i][5];
      rearmPulse = VEC[i][4];
      trigOutAck = VEC[i][3];
      step();
      chk("R3/R4/R6", $sformatf("row %0d trigOut", i), trigOut, VEC[i][2]);
      chk("R2", $sformatf("row %0d trigInAck", i), trigInAck, VEC[i][1]);
      chk("R7", $sformatf("row %0d triggered", i), triggered, VEC[i][0]);
    end
    idle();

    // R6: rearm while the event is still in the delay line
    localHit = 1'b1; step(); localHit = 1'b0;
    repeat (3) step();
    rearmPulse = 1'b1; step(); rearmPulse = 1'b0;
    for (int j = 0; j < 10; j++) begin
      step();
      chk("R6", "flushed event stays hidden", trigOut, 1'b0);
    end
    chk("R6", "triggered after flush", triggered, 1'b0);

    // R5: event held high with ack held high: one short pulse only
    localHit = 1'b1; trigOutAck = 1'b1;
    for (int j = 0; j < 14; j++) begin
      step();
      if (j == 7) chk("R5", "before rise", trigOut, 1'b0);
      if (j == 8) chk("R5", "single rise", trigOut, 1'b1);
      if (j >= 9) chk("R5", "no second rise", trigOut, 1'b0);
    end
    chk("R7", "status held after drop", triggered, 1'b1);
    idle();
    rearmPulse = 1'b1; step(); rearmPulse = 1'b0;
    chk("R6", "rearm clears status", triggered, 1'b0);

    // R1: reset during flight discards the event
    trigIn = 1'b1; step(); trigIn = 1'b0;
    repeat (3) step();
    rst = 1'b1; step(); rst = 1'b0;
    chk("R1", "reset clears trigInAck", trigInAck, 1'b0);
    for (int j = 0; j < 10; j++) begin
      step();
      chk("R1", "no output after reset", trigOut, 1'b0);
    end

    // R8: chained pair
    aLocal = 1'b1; step(); aLocal = 1'b0;
    for (int j = 1; j <= 18; j++) begin
      step();
      if (j == 7)  chk("R8", "A before rise", aOut, 1'b0);
      if (j == 8)  chk("R8", "A rises", aOut, 1'b1);
      if (j == 9)  chk("R8", "B acks", bInAck, 1'b1);
      if (j == 9)  chk("R8", "A holds until ack seen", aOut, 1'b1);
      if (j == 10) chk("R8", "A drops", aOut, 1'b0);
      if (j == 11) chk("R8", "B ack falls", bInAck, 1'b0);
      if (j == 16) chk("R8", "B before rise", bOut, 1'b0);
      if (j == 17) chk("R8", "B rises", bOut, 1'b1);
    end
    chk("R8", "B status", bTrig, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule